// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count and raises a software-interrupt pulse when that count reaches a programmed limit. The count is 63 bits wide and advances once for each cycle in which the prescaler's tick enable is high. The top bit of each 64-bit register has a special meaning. In the count register it is a read-masking control flag that is stored beside the counter. In the limit register it is an interrupt-disable flag.

Software writes the count and the limit through two write strobes and reads the count on a read port. Each limit write arms the compare for exactly one firing. A firing drives a one-cycle pulse on one bit of a software-interrupt set vector. A parameter chooses that bit, so one instance can serve the primary timer bit and others can serve the system timer bit. A limit that is already at or behind the count fires on the next tick. A zero limit never fires.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, `cnt_rdata` reads 0x8000_0000_0000_0000 (control flag one, count zero). The interrupt-disable flag is set and `soft_set` is all zeros.
- R2: A cycle with `cnt_wr` high loads bits 62..0 of `cnt_wdata` into the counter and bit 63 into the control flag. The write wins over a tick in the same cycle.
- R3: `cnt_rdata` shows the counter in bits 62..0. Bit 63 is one when the control flag is set and zero otherwise.
- R4: Each cycle with `tick_en` high and no count write adds one to the 63-bit count. The count wraps from all ones to zero. Without `tick_en`, the count holds.
- R5: After a limit write with bit 63 clear and a nonzero value in bits 62..0, a firing occurs on the tick taken while the count equals the limit, that is, the tick after the count reached it. `soft_set` is high the cycle after that tick.
- R6: If the limit in bits 62..0 is at or below the count when the limit is written, the next tick fires.
- R7: A limit write with bits 62..0 all zero arms nothing, and no pulse follows it.
- R8: A limit write with bit 63 set marks the block as disabled, and no pulse follows it while the limit matches.
- R9: Each limit write allows at most one firing. Later matches produce no pulse until the limit is written again.
- R10: `soft_set` is SOFT_W bits wide. Only bit SOFT_BIT can go high, and each pulse lasts exactly one cycle. A tick in the cycle of a limit write does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable from the prescaler |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value; the top bit goes to the control flag |
| lim_wr | input | 1 | Limit write strobe |
| lim_wdata | input | CNT_W | Limit write value; the top bit is the disable flag |
| cnt_rdata | output | CNT_W | Count read value with the control flag in the top bit |
| soft_set | output | SOFT_W | One-cycle set pulse for the selected software-interrupt bit |

## Verification
The compare is tried with a limit two ticks ahead of the count, and the test checks that the pulse appears on the third tick and not on the first two. It is also tried with a limit behind the count and with a limit equal to the count, which separates the catch-up path from the equality path. Zero limits and limits with the disable bit set are written to confirm that no pulse follows. The count is then rewound past a limit that has already fired, which shows the one-shot behaviour, and counts near the top of the range show the wrap.

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer #(
  parameter int CNT_W    = 64,
  parameter int SOFT_W   = 17,
  parameter int SOFT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              lim_wr,
  input  logic [CNT_W-1:0]  lim_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  output logic [SOFT_W-1:0] soft_set
);
  localparam int LOW_W = CNT_W - 1;

  logic [LOW_W-1:0] cnt_q, lim_q;
  logic             ctrl_q, dis_q, armed_q, late_q, soft_q;
  logic             hit, fire;

  assign hit  = late_q || (cnt_q == lim_q);
  assign fire = tick_en && !lim_wr && armed_q && !dis_q && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ctrl_q  <= 1'b1;
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      late_q  <= 1'b0;
      soft_q  <= 1'b0;
    end else begin
      soft_q <= fire;
      if (cnt_wr) begin
        cnt_q  <= cnt_wdata[LOW_W-1:0];
        ctrl_q <= cnt_wdata[CNT_W-1];
      end else if (tick_en) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (lim_wr) begin
        lim_q   <= lim_wdata[LOW_W-1:0];
        dis_q   <= lim_wdata[CNT_W-1];
        armed_q <= (|lim_wdata[LOW_W-1:0]) && !lim_wdata[CNT_W-1];
        late_q  <= lim_wdata[LOW_W-1:0] <= cnt_q;
      end else if (fire) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
    end
  end

  assign cnt_rdata = {ctrl_q, cnt_q};
  assign soft_set  = {{(SOFT_W-1){1'b0}}, soft_q} << SOFT_BIT;

  assert_cnt_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_rdata == $past(cnt_wdata));

  assert_tick_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tick_en) |=> cnt_rdata[LOW_W-1:0] == $past(cnt_rdata[LOW_W-1:0]) + 1'b1);

  assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !tick_en) |=> $stable(cnt_rdata));

  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && lim_wdata[LOW_W-1:0] == '0) |=> !soft_set[SOFT_BIT] ##1 !soft_set[SOFT_BIT]);

  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr && lim_wdata[CNT_W-1]) |=> !soft_set[SOFT_BIT] ##1 !soft_set[SOFT_BIT]);

  assert_one_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_set & ~(SOFT_W'(1) << SOFT_BIT)) == '0);

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_set[SOFT_BIT] |=> !soft_set[SOFT_BIT]);
endmodule

// File: tb/tick_cmp_timer_tb.sv
`timescale 1ns/1ps
module tick_cmp_timer_tb;
  localparam int W  = 64;
  localparam int SW = 17;
  localparam int SB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0, cnt_wr = 1'b0, lim_wr = 1'b0;
  logic [W-1:0]  cnt_wdata = '0, lim_wdata = '0;
  logic [W-1:0]  cnt_rdata;
  logic [SW-1:0] soft_set;
  int            n_chk = 0, n_fail = 0;
  logic          done = 1'b0;

  localparam logic [SW-1:0] PULSE = SW'(1) << SB;

  always #2.5 clk = ~clk;

  tick_cmp_timer #(.CNT_W(W), .SOFT_W(SW), .SOFT_BIT(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
    .cnt_rdata(cnt_rdata), .soft_set(soft_set));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_cnt(input logic [W-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic write_lim(input logic [W-1:0] v);
    lim_wr = 1'b1; lim_wdata = v;
    @(negedge clk);
    lim_wr = 1'b0;
  endtask

  task automatic tick_once(output logic [SW-1:0] s);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    s = soft_set;
  endtask

  task automatic t_reset;
    check("R1 reset count", cnt_rdata, 64'h8000_0000_0000_0000);
    check("R1 reset soft", W'(soft_set), '0);
  endtask

  task automatic t_count_rw;
    logic [SW-1:0] s;
    write_cnt(64'h8000_0000_0000_1234);
    check("R3 read with flag", cnt_rdata, 64'h8000_0000_0000_1234);
    write_cnt(64'h0000_0000_0000_0055);
    check("R3 read without flag", cnt_rdata, 64'h55);
    tick_once(s);
    check("R4 tick increments", cnt_rdata, 64'h56);
    repeat (3) @(negedge clk);
    check("R4 hold without tick", cnt_rdata, 64'h56);
    tick_en = 1'b1; cnt_wr = 1'b1; cnt_wdata = 64'h99;
    @(negedge clk);
    tick_en = 1'b0; cnt_wr = 1'b0;
    check("R2 write beats tick", cnt_rdata, 64'h99);
    write_cnt(64'h7FFF_FFFF_FFFF_FFFF);
    tick_once(s);
    check("R4 wrap to zero", cnt_rdata, 64'h0);
  endtask

  task automatic t_equal;
    logic [SW-1:0] s;
    write_cnt(64'd10);
    write_lim(64'd12);
    tick_once(s); check("R5 no fire at 10", W'(s), '0);
    tick_once(s); check("R5 no fire at 11", W'(s), '0);
    tick_once(s); check("R5 fire at 12", W'(s), W'(PULSE));
    @(negedge clk);
    check("R10 pulse one cycle", W'(soft_set), '0);
    write_cnt(64'd11);
    tick_once(s);
    tick_once(s); check("R9 no second firing", W'(s), '0);
    tick_once(s); check("R9 still quiet", W'(s), '0);
  endtask

  task automatic t_late;
    logic [SW-1:0] s;
    write_cnt(64'd100);
    write_lim(64'd50);
    tick_once(s); check("R6 past limit fires", W'(s), W'(PULSE));
    write_cnt(64'd200);
    write_lim(64'd200);
    tick_once(s); check("R6 equal limit fires", W'(s), W'(PULSE));
    write_cnt(64'd300);
    lim_wr = 1'b1; lim_wdata = 64'd100; tick_en = 1'b1;
    @(negedge clk);
    lim_wr = 1'b0; tick_en = 1'b0;
    check("R10 no fire on write tick", W'(soft_set), '0);
    tick_once(s); check("R10 fires next tick", W'(s), W'(PULSE));
  endtask

  task automatic t_zero_dis;
    logic [SW-1:0] s;
    logic [SW-1:0] acc;
    write_cnt(64'd0);
    write_lim(64'd0);
    acc = '0;
    repeat (3) begin tick_once(s); acc |= s; end
    check("R7 zero limit silent", W'(acc), '0);
    write_cnt(64'd400);
    write_lim(64'h8000_0000_0000_0191);
    acc = '0;
    repeat (4) begin tick_once(s); acc |= s; end
    check("R8 disabled silent", W'(acc), '0);
    write_lim(64'h8000_0000_0000_0001);
    tick_once(s); check("R8 disabled past limit silent", W'(s), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count_rw();
    t_equal();
    t_late();
    t_zero_dis();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule